// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block turns a 32-word by 4-bit display memory into drive-level codes for a multiplexed liquid-crystal panel with up to four common lines and thirty-two segment lines. A prescaler divides the system clock into an LCD clock, and each common line is selected for one LCD clock period. The divisor is chosen at run time by a clock-source select: a large divisor for a fast RC or external source, and a small one for a low-frequency crystal. The number of scanned commons follows a duty select: two, three or four. The number of intermediate voltage levels follows a bias select: one or two.

A sweeper reads the display memory one word per clock and keeps a local copy of it. For each pin, an encoder then produces a 2-bit code that names one of four voltage rails. An analog ladder and output buffers outside this block apply the rail. After every complete scan of the active commons, all levels are mirrored, so that no pixel sees a net DC voltage. When the panel is disabled, every pin is held at ground.

Top module: `lcd_scan_top`

## Requirements
- R1: During reset, and in the cycle after any cycle in which `lcd_en` is low, every common and segment code is 0 (ground). The same reset sets `mem_addr` to 0.
- R2: Each common phase lasts `DIV_RC` clock cycles while `clk_src_xtal` is 0, and `DIV_XTAL` cycles while it is 1.
- R3: `duty_sel` values 0, 1, 2 and 3 select 2, 3, 4 and 4 active commons. The commons are selected in ascending index order, starting at common 0 when the panel is enabled.
- R4: Commons whose index is not below the active count are driven with code 0.
- R5: The selected common is driven with code 3 in a normal frame and with code 0 in an inverted frame.
- R6: An active common that is not selected is driven with code 1 in a normal frame and code 2 in an inverted frame when `bias_third` is 1. When `bias_third` is 0, it gets code 1 in both frames, and no pin ever carries code 2.
- R7: During phase k, segment n reflects bit k of memory word n. A lit pixel (bit 1) gets code 0 in a normal frame and code 3 in an inverted frame. An unlit pixel gets code 2 in a normal frame and code 1 in an inverted frame at third bias. At half bias it gets code 1 in both frames.
- R8: The frame starts normal on enable, and the frame polarity flips each time the last active common's phase ends.
- R9: `mem_addr` steps through 0 up to `NUM_SEG`-1 and wraps, advancing once per clock. The memory returns the word one cycle after its address, and a memory change reaches the segment codes within 2*`NUM_SEG`+4 cycles.
- R10: Codes are registered. A change of phase, polarity, bias or duty appears on the pins one clock after the cycle in which it takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_src_xtal | input | 1 | 1: low-frequency crystal divisor, 0: RC/external divisor |
| duty_sel | input | 2 | Active common count select (0:2, 1:3, 2/3:4) |
| bias_third | input | 1 | 1: two intermediate levels, 0: one |
| lcd_en | input | 1 | Panel drive enable |
| mem_addr | output | 5 | Display memory read address |
| mem_rdata | input | 4 | Display memory word, one cycle after address |
| com_lvl | output | 8 | Common codes, common k in bits [2k+1:2k] |
| seg_lvl | output | 64 | Segment codes, segment n in bits [2n+1:2n] |

## Verification
The bench keeps the default four commons and thirty-two segments. It lowers the divisors to 24 and 6, so one run covers many complete frames in every duty, bias and source combination, including both polarities and source switches in the middle of a phase. With the short crystal divisor, a phase is shorter than one memory sweep. This exercises a display copy that is only partly refreshed while a phase is running. It also exercises the settling window after memory writes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_GND  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

    // Number of scanned commons for a duty code, clamped to what exists.
    function automatic int unsigned coms_for_duty(input logic [1:0] duty, input int unsigned max_coms);
        int unsigned n;
        case (duty)
            2'd0:    n = 2;
            2'd1:    n = 3;
            default: n = 4;
        endcase
        return (n > max_coms) ? max_coms : n;
    endfunction

    // Level of an active common in a normal frame.
    function automatic lvl_e com_level(input logic selected);
        return selected ? LVL_TOP : LVL_LOW;
    endfunction

    // Level of a segment in a normal frame.
    function automatic lvl_e seg_level(input logic lit, input logic third);
        if (lit) return LVL_GND;
        return third ? LVL_HIGH : LVL_LOW;
    endfunction

    // Mirror for the inverted frame; at half bias the one mid level stays put.
    function automatic lvl_e mirror_lvl(input lvl_e l, input logic inv, input logic third);
        if (!inv) return l;
        if (!third && (l == LVL_LOW || l == LVL_HIGH)) return LVL_LOW;
        return lvl_e'(2'd3 - l);
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NUM_COM  = 4,
    parameter int unsigned DIV_RC   = 1024,
    parameter int unsigned DIV_XTAL = 128
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enable,
    input  logic                          src_xtal,
    input  logic [$clog2(NUM_COM+1)-1:0]  n_active,
    output logic [$clog2(NUM_COM)-1:0]    com_idx,
    output logic                          inv
);
    localparam int unsigned DIV_MAX = (DIV_RC > DIV_XTAL) ? DIV_RC : DIV_XTAL;
    localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);
    localparam int unsigned CW      = $clog2(NUM_COM);
    localparam int unsigned NW      = $clog2(NUM_COM + 1);

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] div_lim;
    logic             phase_end;
    logic             scan_end;

    assign div_lim   = src_xtal ? CNT_W'(DIV_XTAL - 1) : CNT_W'(DIV_RC - 1);
    assign phase_end = (div_cnt >= div_lim);
    assign scan_end  = ((NW'(com_idx) + NW'(1)) >= n_active);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            div_cnt <= '0;
            com_idx <= '0;
            inv     <= 1'b0;
        end else if (phase_end) begin
            div_cnt <= '0;
            if (scan_end) begin
                com_idx <= '0;
                inv     <= ~inv;
            end else begin
                com_idx <= com_idx + CW'(1);
            end
        end else begin
            div_cnt <= div_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lcd_pixel_fetch.sv
module lcd_pixel_fetch
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NUM_SEG = 32,
    parameter int unsigned DW      = 4
) (
    input  logic                                        clk,
    input  logic                                        rst,
    output logic [$clog2(NUM_SEG)-1:0]                  rd_addr,
    input  logic [DW-1:0]                               rd_data,
    output logic [NUM_SEG-1:0][DW-1:0]                  pix
);
    localparam int unsigned AW = $clog2(NUM_SEG);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d1;
    logic          rd_vld;
    logic [DW-1:0] shadow_q [NUM_SEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            addr_d1 <= '0;
            rd_vld  <= 1'b0;
        end else begin
            addr_q  <= (addr_q == AW'(NUM_SEG - 1)) ? '0 : addr_q + AW'(1);
            addr_d1 <= addr_q;
            rd_vld  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < int'(NUM_SEG); g++) shadow_q[g] <= '0;
        end else begin
            for (int g = 0; g < int'(NUM_SEG); g++) begin
                if (rd_vld && addr_d1 == AW'(g)) shadow_q[g] <= rd_data;
            end
        end
    end

    for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_pix
        assign pix[g] = shadow_q[g];
    end

    assign rd_addr = addr_q;

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NUM_COM = 4,
    parameter int unsigned NUM_SEG = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                enable,
    input  logic                                third,
    input  logic [$clog2(NUM_COM+1)-1:0]        n_active,
    input  logic [$clog2(NUM_COM)-1:0]          com_idx,
    input  logic                                inv,
    input  logic [NUM_SEG-1:0][NUM_COM-1:0]     pix,
    output logic [NUM_COM-1:0][1:0]             com_q,
    output logic [NUM_SEG-1:0][1:0]             seg_q
);
    localparam int unsigned CW = $clog2(NUM_COM);
    localparam int unsigned NW = $clog2(NUM_COM + 1);

    logic [NUM_COM-1:0][1:0] com_d;
    logic [NUM_SEG-1:0][1:0] seg_d;

    for (genvar k = 0; k < int'(NUM_COM); k++) begin : g_com
        assign com_d[k] = (NW'(k) >= n_active) ? LVL_GND
                        : mirror_lvl(com_level(com_idx == CW'(k)), inv, third);
    end

    for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_seg
        assign seg_d[g] = mirror_lvl(seg_level(pix[g][com_idx], third), inv, third);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            com_q <= '0;
            seg_q <= '0;
        end else begin
            com_q <= com_d;
            seg_q <= seg_d;
        end
    end

endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
    import lcd_scan_pkg::*;
#(
    parameter int unsigned NUM_COM  = 4,
    parameter int unsigned NUM_SEG  = 32,
    parameter int unsigned DIV_RC   = 1024,
    parameter int unsigned DIV_XTAL = 128
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clk_src_xtal,
    input  logic [1:0]                    duty_sel,
    input  logic                          bias_third,
    input  logic                          lcd_en,
    output logic [$clog2(NUM_SEG)-1:0]    mem_addr,
    input  logic [NUM_COM-1:0]            mem_rdata,
    output logic [NUM_COM*2-1:0]          com_lvl,
    output logic [NUM_SEG*2-1:0]          seg_lvl
);
    localparam int unsigned CW = $clog2(NUM_COM);
    localparam int unsigned NW = $clog2(NUM_COM + 1);

    logic [NW-1:0]                  n_active;
    logic [CW-1:0]                  com_idx;
    logic                           inv;
    logic [NUM_SEG-1:0][NUM_COM-1:0] pix;
    logic [NUM_COM-1:0][1:0]        com_q;
    logic [NUM_SEG-1:0][1:0]        seg_q;

    assign n_active = NW'(coms_for_duty(duty_sel, NUM_COM));

    lcd_frame_timer #(
        .NUM_COM (NUM_COM),
        .DIV_RC  (DIV_RC),
        .DIV_XTAL(DIV_XTAL)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (lcd_en),
        .src_xtal(clk_src_xtal),
        .n_active(n_active),
        .com_idx (com_idx),
        .inv     (inv)
    );

    lcd_pixel_fetch #(
        .NUM_SEG(NUM_SEG),
        .DW     (NUM_COM)
    ) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .rd_addr(mem_addr),
        .rd_data(mem_rdata),
        .pix    (pix)
    );

    lcd_level_enc #(
        .NUM_COM(NUM_COM),
        .NUM_SEG(NUM_SEG)
    ) u_enc (
        .clk     (clk),
        .rst     (rst),
        .enable  (lcd_en),
        .third   (bias_third),
        .n_active(n_active),
        .com_idx (com_idx),
        .inv     (inv),
        .pix     (pix),
        .com_q   (com_q),
        .seg_q   (seg_q)
    );

    assign com_lvl = com_q;
    assign seg_lvl = seg_q;

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int unsigned NUM_COM = 4,
    parameter int unsigned NUM_SEG = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic [1:0]                    duty_sel,
    input logic                          bias_third,
    input logic                          lcd_en,
    input logic [$clog2(NUM_SEG)-1:0]    mem_addr,
    input logic [NUM_COM*2-1:0]          com_lvl,
    input logic [NUM_SEG*2-1:0]          seg_lvl
);
    localparam int unsigned AW = $clog2(NUM_SEG);

    logic [NUM_COM-1:0] com_at_top;
    logic [NUM_COM-1:0] com_at_high;
    logic [NUM_SEG-1:0] seg_at_high;

    for (genvar k = 0; k < int'(NUM_COM); k++) begin : g_ct
        assign com_at_top[k]  = (com_lvl[2*k +: 2] == 2'd3);
        assign com_at_high[k] = (com_lvl[2*k +: 2] == 2'd2);
    end
    for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_sh
        assign seg_at_high[g] = (seg_lvl[2*g +: 2] == 2'd2);
    end

    // R1
    disabled_ground_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_en |=> (com_lvl == '0 && seg_lvl == '0));

    // R5
    one_selected_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_at_top));

    // R6
    half_bias_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bias_third) |-> (com_at_high == '0 && seg_at_high == '0));

    for (genvar k = 2; k < int'(NUM_COM); k++) begin : g_idle
        // R4
        idle_com_ground_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(duty_sel) == 2'd0) |-> (com_lvl[2*k +: 2] == 2'd0));
    end

    // R9
    addr_sweep_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mem_addr == (($past(mem_addr) == AW'(NUM_SEG - 1)) ? '0 : $past(mem_addr) + AW'(1))));

endmodule

bind lcd_scan_top lcd_scan_chk #(
    .NUM_COM(NUM_COM),
    .NUM_SEG(NUM_SEG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .duty_sel  (duty_sel),
    .bias_third(bias_third),
    .lcd_en    (lcd_en),
    .mem_addr  (mem_addr),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
);

// File: tb/lcd_scan_top_bench.sv
module lcd_scan_top_bench;
    localparam int NC   = 4;
    localparam int NS   = 32;
    localparam int DRC  = 24;
    localparam int DXT  = 6;
    localparam int WIN  = 2 * NS + 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clk_src_xtal = 1'b0;
    logic [1:0]      duty_sel = 2'd2;
    logic            bias_third = 1'b1;
    logic            lcd_en = 1'b0;
    logic [4:0]      mem_addr;
    logic [NC-1:0]   mem_rdata = '0;
    logic [NC*2-1:0] com_lvl;
    logic [NS*2-1:0] seg_lvl;

    logic [NC-1:0] mem [NS];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_wr = 0;
    bit done = 0;

    // bench reference model state
    int m_div = 0, m_idx = 0, m_fa = 0;
    bit m_inv = 0;
    logic [NC*2-1:0] e_com = '0;
    logic [NS*2-1:0] e_seg = '0;
    int e_cls [NC];

    always #10 clk = ~clk;

    lcd_scan_top #(.NUM_COM(NC), .NUM_SEG(NS), .DIV_RC(DRC), .DIV_XTAL(DXT)) u_lcd_scan_top (
        .clk(clk), .rst(rst), .clk_src_xtal(clk_src_xtal), .duty_sel(duty_sel),
        .bias_third(bias_third), .lcd_en(lcd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

    function automatic int ncom_of(logic [1:0] d);
        return (d == 2'd0) ? 2 : (d == 2'd1) ? 3 : 4;
    endfunction

    // R4 R5 R6: expected common code
    function automatic logic [1:0] exp_com_code(int k, int idx, bit inv, int n, bit third);
        if (k >= n) return 2'd0;
        if (k == idx) return inv ? 2'd0 : 2'd3;
        if (!third) return 2'd1;
        return inv ? 2'd2 : 2'd1;
    endfunction

    // R7: expected segment code
    function automatic logic [1:0] exp_seg_code(bit lit, bit inv, bit third);
        if (lit) return inv ? 2'd3 : 2'd0;
        if (!third) return 2'd1;
        return inv ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int n;
        int div;
        cyc <= cyc + 1;
        mem_rdata <= mem[mem_addr];
        n = ncom_of(duty_sel);
        div = clk_src_xtal ? DXT : DRC;
        if (rst) begin
            m_div <= 0; m_idx <= 0; m_inv <= 0; m_fa <= 0;
            e_com <= '0; e_seg <= '0;
            for (int k = 0; k < NC; k++) e_cls[k] <= 1;
        end else begin
            m_fa <= (m_fa == NS - 1) ? 0 : m_fa + 1;  // R9
            if (!lcd_en) begin
                m_div <= 0; m_idx <= 0; m_inv <= 0;
                e_com <= '0; e_seg <= '0;
                for (int k = 0; k < NC; k++) e_cls[k] <= 1;
            end else begin
                for (int k = 0; k < NC; k++) begin
                    e_com[2*k +: 2] <= exp_com_code(k, m_idx, m_inv, n, bias_third);
                    e_cls[k] <= (k >= n) ? 4 : (k == m_idx) ? 5 : 6;
                end
                for (int g = 0; g < NS; g++)
                    e_seg[2*g +: 2] <= exp_seg_code(mem[g][m_idx], m_inv, bias_third);
                // R2 R3 R8: phase and polarity advance
                if (m_div >= div - 1) begin
                    m_div <= 0;
                    if (m_idx + 1 >= n) begin m_idx <= 0; m_inv <= ~m_inv; end
                    else m_idx <= m_idx + 1;
                end else m_div <= m_div + 1;
            end
        end
    end

    // lockstep comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && cyc > 2 && !done) begin
            chk("R9 address", 64'(mem_addr), 64'(m_fa));
            for (int k = 0; k < NC; k++) begin
                case (e_cls[k])
                    1: chk("R1 disabled common", 64'(com_lvl[2*k +: 2]), 64'(e_com[2*k +: 2]));
                    4: chk("R4 idle common", 64'(com_lvl[2*k +: 2]), 64'(e_com[2*k +: 2]));
                    5: chk("R3 R5 R8 R10 selected common", 64'(com_lvl[2*k +: 2]), 64'(e_com[2*k +: 2]));
                    default: chk("R6 unselected common", 64'(com_lvl[2*k +: 2]), 64'(e_com[2*k +: 2]));
                endcase
            end
            if (cyc - last_wr > WIN) chk("R7 segments", 64'(seg_lvl), 64'(e_seg));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic fill(int mode);
        for (int g = 0; g < NS; g++) begin
            case (mode)
                0: mem[g] = '0;
                1: mem[g] = '1;
                2: mem[g] = (g % 2 == 0) ? 4'h5 : 4'hA;
                default: mem[g] = 4'($urandom);
            endcase
        end
        last_wr = cyc;
    endtask

    task automatic measure_phase(bit xt, int exp_len);
        int len;
        int guard;
        lcd_en = 0; step(2);
        clk_src_xtal = xt; duty_sel = 2'd2; bias_third = 1; lcd_en = 1;
        guard = 0;
        while (com_lvl[3:2] != 2'd3 && guard < 2000) begin step(1); guard++; end
        len = 0;
        while (com_lvl[3:2] == 2'd3 && len < 2000) begin step(1); len++; end
        chk("R2 phase length", 64'(len), 64'(exp_len));
    endtask

    initial begin
        void'($urandom(32'd4242));
        fill(0);
        rst = 1;
        step(4);
        // R1: reset state
        chk("R1 reset commons", 64'(com_lvl), 64'd0);
        chk("R1 reset segments", 64'(seg_lvl), 64'd0);
        chk("R1 reset address", 64'(mem_addr), 64'd0);
        rst = 0;
        step(2);

        // directed corners
        fill(2); lcd_en = 1; duty_sel = 2'd2; bias_third = 1; step(400);
        fill(1); bias_third = 0; step(300);
        fill(0); duty_sel = 2'd3; bias_third = 1; clk_src_xtal = 1; step(300);
        duty_sel = 2'd0; step(200);
        lcd_en = 0; step(20);
        chk("R1 disabled commons", 64'(com_lvl), 64'd0);
        chk("R1 disabled segments", 64'(seg_lvl), 64'd0);
        measure_phase(1'b1, DXT);
        measure_phase(1'b0, DRC);

        // constrained random configurations
        for (int it = 0; it < 30; it++) begin
            duty_sel = 2'($urandom);
            bias_third = 1'($urandom);
            clk_src_xtal = 1'($urandom);
            lcd_en = ($urandom % 6) != 0;
            if ($urandom % 3 == 0) fill(3);
            step(150 + $urandom % 350);
            if ($urandom % 2 == 0) begin
                clk_src_xtal = ~clk_src_xtal;
                step(100 + $urandom % 100);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule